// File: doc/BRIEF.md
# Calorimeter Trigger Cell Summer

This block forms the energy part of a first-level trigger from calorimeter crystal amplitudes. Every pipeline clock it takes one unsigned digitised sample from each crystal. It scales each sample by its own gain trim and clips the result to the sample width. It then sums the trimmed samples into trigger cells of 24 crystals, each a 4 by 6 patch. The sum runs in two adder stages: groups of eight channels first, then three groups per cell.

The cell sums feed two more results. One is a total-energy sum with a threshold flag. The other is a balance flag, which compares the energy in the first half of the cells with the energy in the second half. All results come out a fixed number of clocks after their samples, and a new sample set is accepted on every clock, so the trigger has no dead time. A small write port loads the gain trims, the energy threshold and the balance shift.

Top module: `trig_cell_summer`

## Requirements
- R1: Each crystal's trimmed value is min(floor(sample × gain / 64), 4095). The gain is an unsigned 8-bit value with 6 fractional bits.
- R2: While `rst_n` is low, every output is zero. Reset sets every gain to 64 (unity), the energy threshold to all ones and the balance shift to 0.
- R3: Cell c outputs the sum of the trimmed values of crystals c×24 to c×24+23. Crystal i is `samples[i*12 +: 12]` and cell c is `cell_sum[c*17 +: 17]`. The sum never wraps, even with all 24 crystals at full scale (98280).
- R4: A sample set present at clock edge n shows on every output from edge n+5 onward. A new sample set is accepted on every edge.
- R5: `total_energy` equals the sum of all cell outputs shown on the same cycle.
- R6: `energy_flag` is 1 exactly when the total is greater than or equal to the programmed threshold.
- R7: The first half of the cells is cells 0 and 1; the second half is cells 2 and 3. `balance_flag` is 1 exactly when |first half − second half| ≤ (total >> shift).
- R8: A write with `cfg_we` high takes effect at the clock edge. Addresses 0 to 95 load the gain of that crystal from `cfg_wdata[7:0]`. Address 96 loads the threshold from all 19 bits. Address 97 loads the shift from `cfg_wdata[3:0]`. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samples | input | 1152 | 96 unsigned 12-bit crystal samples, crystal i at bits i*12 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration address |
| cfg_wdata | input | 19 | Configuration write data |
| cell_sum | output | 68 | Four 17-bit cell sums |
| total_energy | output | 19 | Sum of all cells |
| energy_flag | output | 1 | Total at or above threshold |
| balance_flag | output | 1 | Halves balanced within total >> shift |

## Verification
The bench uses the largest gain on full-scale samples in every crystal. A design that clips wrongly or uses a narrow adder would then wrap the cell or total sums. It checks the threshold and the balance limit at exactly equal values and one count on either side, which exposes a strict comparison or an off-by-one shift.

It writes to addresses just past the defined map and replays a known pattern afterwards. A loose address decode would alter a gain, the threshold or the shift, and the replayed results would change. Random sample sets then stream on consecutive clocks under several random configurations. A pipeline stage that drops a set or misaligns outputs in time would then show mismatched cells and flags.

// File: rtl/trig_cell_summer.sv
module trig_cell_summer #(
  parameter int SAMPLE_W  = 12,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 6,
  parameter int N_CELLS   = 4,
  parameter int CELL_ROWS = 4,
  parameter int CELL_COLS = 6,
  parameter int GROUP     = 8,
  parameter int ADDR_W    = 8,
  parameter int SHIFT_W   = 4,
  localparam int CELL_N   = CELL_ROWS * CELL_COLS,
  localparam int N_CH     = N_CELLS * CELL_N,
  localparam int CELL_W   = SAMPLE_W + $clog2(CELL_N),
  localparam int HALF_W   = CELL_W + $clog2(N_CELLS / 2),
  localparam int TOT_W    = HALF_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_CH*SAMPLE_W-1:0]   samples,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [TOT_W-1:0]           cfg_wdata,
  output logic [N_CELLS*CELL_W-1:0]  cell_sum,
  output logic [TOT_W-1:0]           total_energy,
  output logic                       energy_flag,
  output logic                       balance_flag
);

  localparam int PARTS  = CELL_N / GROUP;
  localparam int N_PART = N_CELLS * PARTS;
  localparam int HALF   = N_CELLS / 2;
  localparam int PSUM_W = SAMPLE_W + $clog2(GROUP);
  localparam int PROD_W = SAMPLE_W + GAIN_W;
  localparam int CH_AW  = $clog2(N_CH);
  localparam logic [ADDR_W-1:0] A_THR   = ADDR_W'(N_CH);
  localparam logic [ADDR_W-1:0] A_SHIFT = ADDR_W'(N_CH + 1);

  logic [GAIN_W-1:0]   gain_q [N_CH];
  logic [TOT_W-1:0]    thr_q;
  logic [SHIFT_W-1:0]  sh_q;

  logic [SAMPLE_W-1:0] corr_q [N_CH];
  logic [PSUM_W-1:0]   psum_q [N_PART];
  logic [CELL_W-1:0]   cell_q [N_CELLS];
  logic [CELL_W-1:0]   cell_d1 [N_CELLS];
  logic [CELL_W-1:0]   cell_d2 [N_CELLS];
  logic [CELL_W-1:0]   cell_d3 [N_CELLS];
  logic [HALF_W-1:0]   lo_q, hi_q, lo_n, hi_n;
  logic [TOT_W-1:0]    tot_q, tot_o;
  logic [HALF_W-1:0]   diff_q;
  logic                ef_q, bf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CH; i++) gain_q[i] <= GAIN_W'(1 << GAIN_FRAC);
      thr_q <= '1;
      sh_q  <= '0;
    end else if (cfg_we) begin
      if (cfg_addr < A_THR)        gain_q[cfg_addr[CH_AW-1:0]] <= cfg_wdata[GAIN_W-1:0];
      else if (cfg_addr == A_THR)  thr_q <= cfg_wdata;
      else if (cfg_addr == A_SHIFT) sh_q <= cfg_wdata[SHIFT_W-1:0];
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_trim
    logic [PROD_W-1:0] prod, scaled;
    assign prod   = PROD_W'(samples[ch*SAMPLE_W +: SAMPLE_W]) * PROD_W'(gain_q[ch]);
    assign scaled = prod >> GAIN_FRAC;
    always_ff @(posedge clk) begin
      if (!rst_n)                             corr_q[ch] <= '0;
      else if (|scaled[PROD_W-1:SAMPLE_W])    corr_q[ch] <= '1;
      else                                    corr_q[ch] <= scaled[SAMPLE_W-1:0];
    end
  end

  for (genvar p = 0; p < N_PART; p++) begin : g_part
    logic [PSUM_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int k = 0; k < GROUP; k++) acc = acc + PSUM_W'(corr_q[p*GROUP + k]);
    end
    always_ff @(posedge clk) psum_q[p] <= rst_n ? acc : '0;
  end

  for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
    logic [CELL_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int k = 0; k < PARTS; k++) acc = acc + CELL_W'(psum_q[c*PARTS + k]);
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cell_q[c]  <= '0;
        cell_d1[c] <= '0;
        cell_d2[c] <= '0;
        cell_d3[c] <= '0;
      end else begin
        cell_q[c]  <= acc;
        cell_d1[c] <= cell_q[c];
        cell_d2[c] <= cell_d1[c];
        cell_d3[c] <= cell_d2[c];
      end
    end
    assign cell_sum[c*CELL_W +: CELL_W] = cell_d3[c];
  end

  always_comb begin
    lo_n = '0;
    hi_n = '0;
    for (int c = 0; c < HALF; c++)       lo_n = lo_n + HALF_W'(cell_q[c]);
    for (int c = HALF; c < N_CELLS; c++) hi_n = hi_n + HALF_W'(cell_q[c]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      tot_q  <= '0;
      diff_q <= '0;
      tot_o  <= '0;
      ef_q   <= 1'b0;
      bf_q   <= 1'b0;
    end else begin
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      tot_q  <= TOT_W'(lo_q) + TOT_W'(hi_q);
      diff_q <= (lo_q >= hi_q) ? lo_q - hi_q : hi_q - lo_q;
      tot_o  <= tot_q;
      ef_q   <= tot_q >= thr_q;
      bf_q   <= TOT_W'(diff_q) <= (tot_q >> sh_q);
    end
  end

  assign total_energy = tot_o;
  assign energy_flag  = ef_q;
  assign balance_flag = bf_q;

endmodule

// File: rtl/trig_cell_summer_chk.sv
module trig_cell_summer_chk #(
  parameter int SAMPLE_W = 12,
  parameter int N_CELLS  = 4,
  parameter int CELL_N   = 24,
  parameter int CELL_W   = 17,
  parameter int TOT_W    = 19,
  parameter int SHIFT_W  = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_CELLS*CELL_W-1:0] cell_sum,
  input logic [TOT_W-1:0]          total_energy,
  input logic                      energy_flag,
  input logic                      balance_flag,
  input logic [TOT_W-1:0]          thr,
  input logic [SHIFT_W-1:0]        sh
);
  localparam int CELL_MAX = CELL_N * ((1 << SAMPLE_W) - 1);

  logic [TOT_W-1:0] lo, hi, all, adiff;
  always_comb begin
    lo = '0;
    hi = '0;
    for (int c = 0; c < N_CELLS / 2; c++)       lo = lo + TOT_W'(cell_sum[c*CELL_W +: CELL_W]);
    for (int c = N_CELLS / 2; c < N_CELLS; c++) hi = hi + TOT_W'(cell_sum[c*CELL_W +: CELL_W]);
    all   = lo + hi;
    adiff = (lo >= hi) ? lo - hi : hi - lo;
  end

  for (genvar c = 0; c < N_CELLS; c++) begin : g_ovf
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cell_sum[c*CELL_W +: CELL_W] <= CELL_W'(CELL_MAX));
  end

  a_r5_total_matches_cells: assert property (@(posedge clk) disable iff (!rst_n)
    total_energy == all);

  a_r6_energy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (energy_flag == (total_energy >= $past(thr))));

  a_r7_balance_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (balance_flag == (adiff <= (total_energy >> $past(sh)))));

endmodule

bind trig_cell_summer trig_cell_summer_chk #(
  .SAMPLE_W(SAMPLE_W), .N_CELLS(N_CELLS), .CELL_N(CELL_N),
  .CELL_W(CELL_W), .TOT_W(TOT_W), .SHIFT_W(SHIFT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cell_sum(cell_sum), .total_energy(total_energy),
  .energy_flag(energy_flag), .balance_flag(balance_flag), .thr(thr_q), .sh(sh_q)
);

// File: tb/test_trig_cell_summer.sv
module test_trig_cell_summer;
  localparam int SW  = 12;
  localparam int NC  = 4;
  localparam int CN  = 24;
  localparam int NCH = NC * CN;
  localparam int CW  = 17;
  localparam int TW  = 19;
  localparam int LAT = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NCH*SW-1:0] samples = '0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_addr = '0;
  logic [TW-1:0] cfg_wdata = '0;
  logic [NC*CW-1:0] cell_sum;
  logic [TW-1:0] total_energy;
  logic          energy_flag, balance_flag;

  trig_cell_summer i_trig_cell_summer (
    .clk(clk), .rst_n(rst_n), .samples(samples), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cell_sum(cell_sum),
    .total_energy(total_energy), .energy_flag(energy_flag), .balance_flag(balance_flag)
  );

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, cnt = 0;
  bit done = 0;
  int unsigned gm [NCH];
  int unsigned thr_m, sh_m;
  int unsigned smp [NCH];
  int unsigned e_cell [8][NC];
  int unsigned e_tot [8];
  int unsigned e_ef [8], e_bf [8];

  function automatic int unsigned trim(int unsigned s, int unsigned g);
    int unsigned p = (s * g) >> 6;
    return (p > 4095) ? 4095 : p;
  endfunction

  task automatic chk(string what, int unsigned act, int unsigned exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic model(int slot);
    int unsigned lo = 0, hi = 0, d;
    for (int c = 0; c < NC; c++) begin
      int unsigned s = 0;
      for (int j = 0; j < CN; j++) s += trim(smp[c*CN + j], gm[c*CN + j]);
      e_cell[slot][c] = s;
      if (c < NC / 2) lo += s; else hi += s;
    end
    e_tot[slot] = lo + hi;
    d = (lo >= hi) ? lo - hi : hi - lo;
    e_ef[slot] = (e_tot[slot] >= thr_m) ? 1 : 0;
    e_bf[slot] = (d <= (e_tot[slot] >> sh_m)) ? 1 : 0;
  endtask

  // R4: outputs checked every cycle against the set driven six edges earlier
  task automatic step(string tag);
    @(negedge clk);
    if (cnt >= LAT) begin
      int k = (cnt - LAT) % 8;
      for (int c = 0; c < NC; c++)
        chk({tag, " R3 R4 cell sum"}, cell_sum[c*CW +: CW], e_cell[k][c]);
      chk({tag, " R5 total"}, total_energy, e_tot[k]);
      chk({tag, " R6 energy flag"}, energy_flag, e_ef[k]);
      chk({tag, " R7 balance flag"}, balance_flag, e_bf[k]);
    end
    for (int i = 0; i < NCH; i++) samples[i*SW +: SW] = SW'(smp[i]);
    model(cnt % 8);
    cnt++;
  endtask

  task automatic flush(string tag);
    for (int i = 0; i < NCH; i++) smp[i] = 0;
    repeat (LAT) step(tag);
    cnt = 0;
  endtask

  // R8 register map mirrored in the bench
  task automatic wr(int unsigned a, int unsigned d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = TW'(d);
    @(posedge clk);
    #1 cfg_we = 1'b0;
    if (a < NCH) gm[a] = d & 255;
    else if (a == NCH) thr_m = d & ((1 << TW) - 1);
    else if (a == NCH + 1) sh_m = d & 15;
  endtask

  task automatic set_all(int unsigned v);
    for (int i = 0; i < NCH; i++) smp[i] = v;
  endtask

  task automatic set_rand();
    for (int i = 0; i < NCH; i++) smp[i] = $urandom % 4096;
  endtask

  task automatic pair(int unsigned a, int unsigned b);
    set_all(0);
    smp[0] = a;
    smp[2*CN] = b;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240517);
    for (int i = 0; i < NCH; i++) gm[i] = 64;
    thr_m = (1 << TW) - 1;
    sh_m = 0;
    set_rand();
    for (int i = 0; i < NCH; i++) samples[i*SW +: SW] = SW'(smp[i]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: outputs held at zero in reset
    chk("R2 reset cell sums", (cell_sum == '0) ? 1 : 0, 1);
    chk("R2 reset total", total_energy, 0);
    chk("R2 reset energy flag", energy_flag, 0);
    chk("R2 reset balance flag", balance_flag, 0);
    rst_n = 1'b1;
    cnt = 0;

    // R2 default gains and thresholds
    repeat (20) begin set_rand(); step("R2 defaults"); end
    flush("R2 defaults");

    // R1 saturation with largest gain; R3 full-scale cells; R6 equal threshold
    for (int i = 0; i < NCH; i++) wr(i, 255);
    wr(NCH, 393120);
    set_all(4095); step("R1 saturate");
    set_all(4095); step("R1 saturate");
    set_all(16);   step("R1 gain");
    set_rand();    step("R1 gain");
    flush("R1 saturate");

    // R7 and R6 boundaries with unity gain
    for (int i = 0; i < NCH; i++) wr(i, 64);
    wr(NCH, 800);
    wr(NCH + 1, 2);
    pair(500, 300); step("R7 at limit");
    pair(501, 300); step("R7 over limit");
    pair(499, 300); step("R6 below threshold");
    pair(300, 501); step("R7 mirrored");
    flush("R7 boundary");

    // R8 writes outside the map change nothing
    wr(NCH + 2, 0);
    wr(NCH + 3, 1);
    wr(255, 0);
    wr(NCH - 1, 128);
    pair(500, 300); step("R8 ignored address");
    pair(501, 300); step("R8 ignored address");
    set_all(0); smp[NCH-1] = 1000; step("R8 last gain");
    flush("R8 map");

    // random configurations with streaming random samples
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < NCH; i++) wr(i, $urandom % 256);
      wr(NCH, $urandom % 400000);
      wr(NCH + 1, $urandom % 16);
      for (int n = 0; n < 60; n++) begin
        if (n % 7 == 3) set_all(4095);
        else set_rand();
        step("R4 random stream");
      end
      flush("R4 random stream");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog R4 actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule